// File: doc/BRIEF.md
# Sequential Divider with Zero-Divisor Flags

This block divides one 32-bit operand by another, in either two's-complement or unsigned form, and returns the quotient. Any non-zero divisor goes through a fixed number of shift-and-subtract iterations on the operand magnitudes. A divisor of zero is not computed. The block finishes at once, does not write a quotient, and raises an error flag. A range-exception request goes out with that flag when the caller's exception enable is set.

The caller pulses `start_i` while the block is idle, with the operands, the signed/unsigned select and the exception enable. The block then holds `busy_o` until its one-cycle `done_o`. In the done cycle it presents four things:
- the quotient and its write enable;
- the flag value;
- a strobe naming which status bit the flag updates: the overflow bit for signed division, the carry bit for unsigned division;
- the range-exception request.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o`, `quot_we_o`, `flag_ov_we_o`, `flag_cy_we_o` and `range_exc_o` are 0 until a start is accepted.
- R2: With `signed_i`=0 and a non-zero divisor, `done_o` is high in the cycle after the 33rd rising edge, counting the edge that samples `start_i` as the first. In that cycle `quot_o` equals the unsigned quotient rounded down and `quot_we_o` is 1.
- R3: With `signed_i`=1 and a non-zero divisor, `quot_o` equals the two's-complement quotient truncated toward zero. Its sign is negative exactly when the operand signs differ and the magnitude is non-zero.
- R4: Signed division of 0x80000000 by 0xFFFFFFFF returns 0x80000000 with `quot_we_o`=1 and `flag_value_o`=0.
- R5: A divisor of 0 completes with `done_o` high in the cycle right after the sampling edge. In that cycle `quot_we_o` is 0 and `flag_value_o` is 1.
- R6: In the done cycle, exactly one strobe is high. `flag_ov_we_o` is high for signed division and `flag_cy_we_o` for unsigned division. `flag_value_o` is 0 whenever the divisor was non-zero.
- R7: In the done cycle, `range_exc_o` is 1 exactly when the divisor was 0 and `exc_en_i` was 1 at the sampling edge.
- R8: `busy_o` is high from the cycle after an accepted start through the done cycle. A `start_i` seen while `busy_o` is high is ignored and leaves the running result unchanged.
- R9: `done_o` lasts one cycle. `quot_we_o`, both flag strobes and `range_exc_o` are 0 outside the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; taken only when idle |
| signed_i | input | 1 | 1: two's-complement division, 0: unsigned |
| dividend_i | input | 32 | Dividend, sampled with the start |
| divisor_i | input | 32 | Divisor, sampled with the start |
| exc_en_i | input | 1 | Allow a range-exception request on a zero divisor |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 32 | Quotient, valid when `quot_we_o` is high |
| quot_we_o | output | 1 | Write enable for the quotient |
| flag_value_o | output | 1 | Value for the status bit selected by the strobes |
| flag_ov_we_o | output | 1 | Update the overflow bit (signed division) |
| flag_cy_we_o | output | 1 | Update the carry bit (unsigned division) |
| range_exc_o | output | 1 | Range-exception request |

## Verification
The hardest situation to reach from the ports is a new request that arrives while an earlier division is still iterating. The stimulus holds `start_i` high for several cycles in mid-run with different operands, and the first result must still come out intact. The zero-divisor path and the most-negative-by-minus-one case are also driven on purpose, with both settings of the exception enable, because random operands almost never produce them. A behavioural model in the bench predicts `busy_o`, `done_o` and every strobe on every clock. It also restates the quotient with wide integer arithmetic.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  input  logic         signed_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_q_o,
  output logic         zero_o
);
  // Magnitude of an operand; unsigned operands pass through.
  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic s);
    if (s && v[W-1]) return (~v) + W'(1);
    return v;
  endfunction

  always_comb begin
    mag_a_o = magnitude(dividend_i, signed_i);
    mag_b_o = magnitude(divisor_i, signed_i);
    neg_q_o = signed_i && (dividend_i[W-1] ^ divisor_i[W-1]);
    zero_o  = (divisor_i == '0);
  end
endmodule

// File: rtl/div_seq_ctrl.sv
module div_seq_ctrl
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic zero_i,
  output logic accept_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNTW = $clog2(W);

  div_state_e       state_q;
  logic [CNTW-1:0]  cnt_q;
  logic             last_step;

  always_comb begin
    accept_o  = start_i && (state_q == ST_IDLE);
    step_o    = (state_q == ST_RUN);
    last_step = step_o && (cnt_q == CNTW'(W - 1));
    busy_o    = (state_q != ST_IDLE);
    done_o    = (state_q == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            cnt_q   <= '0;
            state_q <= zero_i ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CNTW'(1);
          if (last_step) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_iter_core.sv
module div_iter_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] mag_b_i,
  output logic [W-1:0] quot_mag_o
);
  logic [W-1:0] rem_q;
  logic [W-1:0] acc_q;
  logic [W-1:0] dsr_q;
  logic [W:0]   step_res;

  // One restoring step: returns {quotient bit, next partial remainder}.
  function automatic logic [W:0] div_step(input logic [W-1:0] rem,
                                          input logic         bit_in,
                                          input logic [W-1:0] dsr);
    logic [W:0]   shifted;
    logic [W+1:0] diff;
    shifted = {rem, bit_in};
    diff    = {1'b0, shifted} - {2'b00, dsr};
    if (!diff[W+1]) return {1'b1, diff[W-1:0]};
    return {1'b0, shifted[W-1:0]};
  endfunction

  assign step_res   = div_step(rem_q, acc_q[W-1], dsr_q);
  assign quot_mag_o = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      acc_q <= '0;
      dsr_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      acc_q <= mag_a_i;
      dsr_q <= mag_b_i;
    end else if (step_i) begin
      rem_q <= step_res[W-1:0];
      acc_q <= {acc_q[W-2:0], step_res[W]};
    end
  end
endmodule

// File: rtl/div_result_fmt.sv
module div_result_fmt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         signed_i,
  input  logic         neg_i,
  input  logic         zero_i,
  input  logic         exc_en_i,
  input  logic         done_i,
  input  logic [W-1:0] quot_mag_i,
  output logic [W-1:0] quot_o,
  output logic         quot_we_o,
  output logic         flag_value_o,
  output logic         flag_ov_we_o,
  output logic         flag_cy_we_o,
  output logic         range_exc_o
);
  logic sgn_q, neg_q, zero_q, exc_q;

  function automatic logic [W-1:0] apply_sign(input logic [W-1:0] mag, input logic neg);
    if (neg) return (~mag) + W'(1);
    return mag;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgn_q  <= 1'b0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
      exc_q  <= 1'b0;
    end else if (load_i) begin
      sgn_q  <= signed_i;
      neg_q  <= neg_i;
      zero_q <= zero_i;
      exc_q  <= exc_en_i;
    end
  end

  always_comb begin
    quot_o       = apply_sign(quot_mag_i, neg_q);
    quot_we_o    = done_i && !zero_q;
    flag_value_o = zero_q;
    flag_ov_we_o = done_i && sgn_q;
    flag_cy_we_o = done_i && !sgn_q;
    range_exc_o  = done_i && zero_q && exc_q;
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  input  logic         exc_en_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic         quot_we_o,
  output logic         flag_value_o,
  output logic         flag_ov_we_o,
  output logic         flag_cy_we_o,
  output logic         range_exc_o
);
  // Internal events, named for the bound checker.
  logic [W-1:0] mag_a_w, mag_b_w, quot_mag_w;
  logic         neg_q_w, div_zero_w, accept_w, step_w;

  div_operand_prep #(.W(W)) u_prep (
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .signed_i   (signed_i),
    .mag_a_o    (mag_a_w),
    .mag_b_o    (mag_b_w),
    .neg_q_o    (neg_q_w),
    .zero_o     (div_zero_w)
  );

  div_seq_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .zero_i   (div_zero_w),
    .accept_o (accept_w),
    .step_o   (step_w),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  div_iter_core #(.W(W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept_w),
    .step_i     (step_w),
    .mag_a_i    (mag_a_w),
    .mag_b_i    (mag_b_w),
    .quot_mag_o (quot_mag_w)
  );

  div_result_fmt #(.W(W)) u_fmt (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (accept_w),
    .signed_i     (signed_i),
    .neg_i        (neg_q_w),
    .zero_i       (div_zero_w),
    .exc_en_i     (exc_en_i),
    .done_i       (done_o),
    .quot_mag_i   (quot_mag_w),
    .quot_o       (quot_o),
    .quot_we_o    (quot_we_o),
    .flag_value_o (flag_value_o),
    .flag_ov_we_o (flag_ov_we_o),
    .flag_cy_we_o (flag_cy_we_o),
    .range_exc_o  (range_exc_o)
  );
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W = 32
) (
  input logic clk,
  input logic rst_n,
  input logic accept_i,
  input logic zero_i,
  input logic busy_i,
  input logic done_i,
  input logic quot_we_i,
  input logic flag_value_i,
  input logic ov_we_i,
  input logic cy_we_i,
  input logic range_exc_i
);
  localparam int LW = $clog2(W + 2) + 1;

  logic [LW-1:0] lat_q;
  logic          zl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      zl_q  <= 1'b0;
    end else if (accept_i) begin
      lat_q <= LW'(1);
      zl_q  <= zero_i;
    end else if (busy_i && !done_i) begin
      lat_q <= lat_q + LW'(1);
    end
  end

  AST_LATENCY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !zl_q) |-> (lat_q == LW'(W + 1))); // R2
  AST_LATENCY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && zl_q) |-> (lat_q == LW'(1))); // R5
  AST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && flag_value_i) |-> !quot_we_i); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> ($countones({ov_we_i, cy_we_i}) == 1)); // R6
  AST_NONZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !flag_value_i) |-> quot_we_i); // R6
  AST_EXC_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    range_exc_i |-> (done_i && flag_value_i)); // R7
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |-> !busy_i); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !done_i) |=> busy_i); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !done_i); // R9
  AST_STROBES_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (quot_we_i || ov_we_i || cy_we_i) |-> done_i); // R9
endmodule

bind seq_divider div_checker #(.W(W)) u_div_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept_i     (accept_w),
  .zero_i       (div_zero_w),
  .busy_i       (busy_o),
  .done_i       (done_o),
  .quot_we_i    (quot_we_o),
  .flag_value_i (flag_value_o),
  .ov_we_i      (flag_ov_we_o),
  .cy_we_i      (flag_cy_we_o),
  .range_exc_i  (range_exc_o)
);

// File: tb/test_seq_divider.sv
module test_seq_divider;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         exc_en_i = 1'b0;
  logic         busy_o, done_o, quot_we_o, flag_value_o;
  logic         flag_ov_we_o, flag_cy_we_o, range_exc_o;
  logic [W-1:0] quot_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  seq_divider #(.W(W)) i_seq_divider (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i), .exc_en_i(exc_en_i),
    .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o), .quot_we_o(quot_we_o),
    .flag_value_o(flag_value_o), .flag_ov_we_o(flag_ov_we_o),
    .flag_cy_we_o(flag_cy_we_o), .range_exc_o(range_exc_o)
  );

  // Reference quotient from wide integer arithmetic.
  function automatic logic [W-1:0] ref_quot(input bit s, input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    longint sa, sb;
    if (b == '0) return '0;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return W'(sa / sb);
    end
    return a / b;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural model, advanced on every rising edge.
  bit           m_busy = 0, m_done = 0, m_zero = 0, m_sgn = 0, m_exc = 0;
  int           m_wait = 0;
  logic [W-1:0] m_q = '0;
  logic [W-1:0] pending_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_wait = 0;
    end else if (m_done) begin
      m_done = 0; m_busy = 0;
    end else if (m_busy) begin
      m_wait--;
      if (m_wait == 0) m_done = 1;
    end else if (start_i) begin
      m_busy = 1;
      m_zero = (divisor_i == '0);
      m_sgn  = signed_i;
      m_exc  = exc_en_i;
      pending_q.push_back(ref_quot(signed_i, dividend_i, divisor_i));
      if (m_zero) m_done = 1;
      else m_wait = W;
    end
  end

  // Compare against the model away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 busy", W'(busy_o), W'(m_busy));
      chk(m_zero ? "R5 done timing" : "R2 done timing", W'(done_o), W'(m_done));
      if (m_done) begin
        if (pending_q.size() > 0) m_q = pending_q.pop_front();
        chk("R5 quotient write enable", W'(quot_we_o), W'(!m_zero));
        if (!m_zero) chk(m_sgn ? "R3 signed quotient" : "R2 unsigned quotient", quot_o, m_q);
        chk(m_zero ? "R5 flag value" : "R6 flag value", W'(flag_value_o), W'(m_zero));
        chk("R6 overflow strobe", W'(flag_ov_we_o), W'(m_sgn));
        chk("R6 carry strobe", W'(flag_cy_we_o), W'(!m_sgn));
        chk("R7 range exception", W'(range_exc_o), W'(m_zero && m_exc));
      end else begin
        chk("R9 strobes outside done",
            W'(quot_we_o | flag_ov_we_o | flag_cy_we_o | range_exc_o), '0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", cycles, WATCHDOG_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_op(input bit s, input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit e, output logic [W-1:0] q, output logic fv);
    @(negedge clk);
    start_i = 1'b1; signed_i = s; dividend_i = a; divisor_i = b; exc_en_i = e;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    q  = quot_o;
    fv = flag_value_o;
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] q;
    logic         fv;

    repeat (3) @(negedge clk);
    chk("R1 reset busy", W'(busy_o), '0);
    chk("R1 reset done", W'(done_o), '0);
    chk("R1 reset strobes",
        W'(quot_we_o | flag_ov_we_o | flag_cy_we_o | range_exc_o), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", W'(busy_o | done_o), '0);

    run_op(0, 32'd100, 32'd7, 0, q, fv);           chk("R2 100/7", q, 32'd14);
    run_op(0, 32'hFFFF_FFFF, 32'd1, 0, q, fv);     chk("R2 max/1", q, 32'hFFFF_FFFF);
    run_op(0, 32'd5, 32'd10, 0, q, fv);            chk("R2 5/10", q, 32'd0);
    run_op(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, q, fv); chk("R2 max/max", q, 32'd1);
    run_op(0, 32'h8000_0000, 32'hFFFF_FFFF, 0, q, fv); chk("R2 unsigned big divisor", q, 32'd0);
    run_op(1, -32'sd100, 32'sd7, 0, q, fv);        chk("R3 -100/7", q, 32'hFFFF_FFF2);
    run_op(1, 32'sd100, -32'sd7, 0, q, fv);        chk("R3 100/-7", q, 32'hFFFF_FFF2);
    run_op(1, -32'sd100, -32'sd7, 0, q, fv);       chk("R3 -100/-7", q, 32'd14);
    run_op(1, -32'sd3, 32'sd7, 0, q, fv);          chk("R3 -3/7 zero", q, 32'd0);
    run_op(1, 32'h8000_0000, 32'hFFFF_FFFF, 1, q, fv);
    chk("R4 min/-1 quotient", q, 32'h8000_0000);
    chk("R4 min/-1 flag", W'(fv), '0);
    run_op(1, 32'h8000_0000, 32'd1, 0, q, fv);     chk("R3 min/1", q, 32'h8000_0000);
    run_op(1, 32'd55, 32'd0, 1, q, fv);            chk("R5 signed zero flag", W'(fv), 32'd1);
    run_op(1, 32'd55, 32'd0, 0, q, fv);            chk("R7 signed zero no exc flag", W'(fv), 32'd1);
    run_op(0, 32'd9, 32'd0, 1, q, fv);             chk("R5 unsigned zero flag", W'(fv), 32'd1);
    run_op(0, 32'd0, 32'd0, 0, q, fv);             chk("R7 unsigned zero no exc flag", W'(fv), 32'd1);

    // Start held in mid-run with other operands must be ignored.
    @(negedge clk);
    start_i = 1'b1; signed_i = 1'b0; dividend_i = 32'd1000; divisor_i = 32'd3; exc_en_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    start_i = 1'b1; signed_i = 1'b1; dividend_i = 32'd7; divisor_i = 32'd0; exc_en_i = 1'b1;
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk("R8 ignored start quotient", quot_o, 32'd333);
    chk("R8 ignored start exception", W'(range_exc_o), '0);
    @(negedge clk);
    chk("R9 done is one cycle", W'(done_o), '0);

    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a, b;
      bit s;
      a = $urandom();
      b = ($urandom() % 5 == 0) ? '0 : (($urandom() % 2) ? W'($urandom() % 50) : $urandom());
      s = $urandom() % 2;
      run_op(s, a, b, $urandom() % 2, q, fv);
      if (b != '0) chk(s ? "R3 random signed" : "R2 random unsigned", q, ref_quot(s, a, b));
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule